// File: doc/BRIEF.md
# Load-Pair Instruction Decoder

This block is a purely combinational classifier for the load-pair group of 32-bit instruction words. It covers both the integer and the SIMD/FP register files. For each word it reports whether the word is a usable load-pair and which register file it targets. It also gives the width of each element in bytes and the addressing form, plus the byte offset already sign-extended and scaled by the element width.

The two destination indices and the base index come straight from their bit fields. Side flags mark base-register writeback, post-indexing, a base that names the stack pointer, and two destinations that name the same register. A word that belongs to the group but carries a reserved width code is marked illegal rather than valid, so the issue stage can raise an undefined-instruction fault.

Memory access, register writes and permission checks belong to later stages. The decoder only prepares the fields those stages consume.

Top module: `ldpair_decode`

## Requirements
- R1: `pair_ok` is 1 exactly when all of the following hold, and 0 for every other word: bits [29:27] are 3'b101, bit 22 is 1, bits [25:23] are one of 3'b001, 3'b010 or 3'b011, and the width code in bits [31:30] is legal for the register file.
- R2: `bad_size` is 1 exactly when the word meets the group test of R1 (bits [29:27], bit 22 and the addressing bits) but the width code is reserved. Width code 2'b11 is reserved for either register file, and 2'b01 is reserved for integer registers. When `bad_size` is 1, `pair_ok` is 0.
- R3: `vec_rf` equals bit 26 (1 = SIMD/FP, 0 = integer) when `pair_ok` is 1, and is 0 otherwise.
- R4: `elem_bytes` is 4, 8 or 16 for SIMD/FP width codes 2'b00, 2'b01 and 2'b10. It is 4 or 8 for integer width codes 2'b00 and 2'b10. It is 0 when `pair_ok` is 0.
- R5: `amode` is 2'b00 for signed-offset form (bits [25:23] = 3'b010), 2'b01 for pre-index (3'b011) and 2'b10 for post-index (3'b001). `wb` is 1 for pre- and post-index, and `post` is 1 only for post-index. All three are 0 when `pair_ok` is 0.
- R6: `byte_off` is the 7-bit field in bits [21:15], sign-extended to OFF_W bits and shifted left by log2 of `elem_bytes`. It is 0 when `pair_ok` is 0.
- R7: `rd_a` equals bits [4:0], `rd_b` equals bits [14:10] and `rbase` equals bits [9:5], for every word.
- R8: `base_sp` is 1 when `pair_ok` is 1 and the base index is 31, and is 0 otherwise.
- R9: `same_dst` is 1 when `pair_ok` is 1 and `rd_a` equals `rd_b`, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word to classify |
| pair_ok | output | 1 | Word is a legal load-pair |
| bad_size | output | 1 | Load-pair group with a reserved width code |
| vec_rf | output | 1 | Destinations are SIMD/FP registers |
| elem_bytes | output | 5 | Bytes per loaded element |
| amode | output | 2 | Addressing form: 00 offset, 01 pre, 10 post |
| wb | output | 1 | Base register is written back |
| post | output | 1 | Offset is applied after the access |
| byte_off | output | OFF_W | Scaled, sign-extended byte offset |
| rd_a | output | 5 | First destination index |
| rd_b | output | 5 | Second destination index |
| rbase | output | 5 | Base register index |
| base_sp | output | 1 | Base is the stack pointer |
| same_dst | output | 1 | Both destinations are the same register |

## Verification
The bench targets the offset extremes: field values 0x3F, 0x40 and 0x7F at every width. A design that sign-extends after scaling, or scales by the wrong width, would produce a wrong or positive offset there.

It also sends near-miss words: the store form, addressing code 000, a cleared bit 27, and integer width code 01. A loose group match would call these valid, and a decoder that ignores the integer reservation would report an 8-byte load.

Base index 31 and equal destinations are driven alongside invalid words, which exposes flags that are not gated by validity. A seeded stream of words whose upper bits are mostly fixed fills in the combinations between these cases.

// File: rtl/ldpair_decode.sv
module ldpair_decode #(
  parameter int OFF_W = 64
) (
  input  logic [31:0]      insn,
  output logic             pair_ok,
  output logic             bad_size,
  output logic             vec_rf,
  output logic [4:0]       elem_bytes,
  output logic [1:0]       amode,
  output logic             wb,
  output logic             post,
  output logic [OFF_W-1:0] byte_off,
  output logic [4:0]       rd_a,
  output logic [4:0]       rd_b,
  output logic [4:0]       rbase,
  output logic             base_sp,
  output logic             same_dst
);
  localparam int IMM_W = 7;
  localparam int EXT_W = OFF_W - IMM_W;

  logic [1:0]       szc;
  logic [2:0]       form;
  logic             fp;
  logic             form_ok;
  logic             group;
  logic             size_ok;
  logic [2:0]       shamt;
  logic [1:0]       mode_raw;
  logic [OFF_W-1:0] imm_ext;

  assign szc  = insn[31:30];
  assign fp   = insn[26];
  assign form = insn[25:23];

  always_comb begin
    form_ok  = 1'b1;
    mode_raw = 2'b00;
    unique case (form)
      3'b010:  mode_raw = 2'b00;
      3'b011:  mode_raw = 2'b01;
      3'b001:  mode_raw = 2'b10;
      default: form_ok  = 1'b0;
    endcase
  end

  assign group   = (insn[29:27] == 3'b101) && insn[22] && form_ok;
  assign size_ok = fp ? (szc != 2'b11) : (szc == 2'b00 || szc == 2'b10);

  assign pair_ok  = group & size_ok;
  assign bad_size = group & ~size_ok;

  assign shamt   = fp ? {1'b0, szc} + 3'd2 : (szc[1] ? 3'd3 : 3'd2);
  assign imm_ext = {{EXT_W{insn[21]}}, insn[21:15]};

  assign vec_rf     = pair_ok & fp;
  assign elem_bytes = pair_ok ? (5'd1 << shamt) : 5'd0;
  assign amode      = pair_ok ? mode_raw : 2'b00;
  assign wb         = pair_ok & (mode_raw != 2'b00);
  assign post       = pair_ok & (mode_raw == 2'b10);
  assign byte_off   = pair_ok ? (imm_ext << shamt) : '0;

  assign rd_a  = insn[4:0];
  assign rd_b  = insn[14:10];
  assign rbase = insn[9:5];

  assign base_sp  = pair_ok & (&insn[9:5]);
  assign same_dst = pair_ok & (insn[4:0] == insn[14:10]);
endmodule

module ldpair_decode_chk #(
  parameter int OFF_W = 64
) (
  input logic [31:0]      insn,
  input logic             pair_ok,
  input logic             bad_size,
  input logic             vec_rf,
  input logic [4:0]       elem_bytes,
  input logic [1:0]       amode,
  input logic             wb,
  input logic             post,
  input logic [OFF_W-1:0] byte_off,
  input logic [4:0]       rd_a,
  input logic [4:0]       rd_b,
  input logic [4:0]       rbase,
  input logic             base_sp,
  input logic             same_dst
);
  always_comb begin
    p_exclusive_r2: assert (!(pair_ok && bad_size));
    p_post_implies_wb_r5: assert (!post || (wb && amode == 2'b10));
    p_size_onehot_r4: assert (!pair_ok || (elem_bytes inside {5'd4, 5'd8, 5'd16}));
    p_int_no_quad_r3: assert (!(pair_ok && !vec_rf) || elem_bytes != 5'd16);
    p_off_aligned_r6: assert (!pair_ok || ((byte_off[4:0] & (elem_bytes - 5'd1)) == 5'd0));
    p_invalid_quiet_r5: assert (pair_ok || (!wb && !post && amode == 2'b00 && elem_bytes == 5'd0));
    p_sp_flag_r8: assert (!base_sp || (pair_ok && rbase == 5'd31));
    p_dup_flag_r9: assert (!same_dst || (pair_ok && rd_a == rd_b));
    p_fields_r7: assert (rd_a == insn[4:0] && rbase == insn[9:5]);
  end
endmodule

bind ldpair_decode ldpair_decode_chk #(.OFF_W(OFF_W)) u_chk (
  .insn(insn), .pair_ok(pair_ok), .bad_size(bad_size), .vec_rf(vec_rf),
  .elem_bytes(elem_bytes), .amode(amode), .wb(wb), .post(post),
  .byte_off(byte_off), .rd_a(rd_a), .rd_b(rd_b), .rbase(rbase),
  .base_sp(base_sp), .same_dst(same_dst)
);

// File: tb/tb_ldpair_decode.sv
`timescale 1ns/1ps
module tb_ldpair_decode;
  localparam int OFF_W = 64;

  typedef struct {
    logic [31:0]      w;
    logic             ok, bad, vec, wbk, pst, sp, dup;
    logic [4:0]       nb, a, b, n;
    logic [1:0]       md;
    logic [OFF_W-1:0] off;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] insn = 32'h0;
  logic pair_ok, bad_size, vec_rf, wb, post, base_sp, same_dst;
  logic [4:0] elem_bytes, rd_a, rd_b, rbase;
  logic [1:0] amode;
  logic [OFF_W-1:0] byte_off;

  int checks = 0;
  int fails = 0;
  bit drv_done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  ldpair_decode #(.OFF_W(OFF_W)) dut (
    .insn(insn), .pair_ok(pair_ok), .bad_size(bad_size), .vec_rf(vec_rf),
    .elem_bytes(elem_bytes), .amode(amode), .wb(wb), .post(post),
    .byte_off(byte_off), .rd_a(rd_a), .rd_b(rd_b), .rbase(rbase),
    .base_sp(base_sp), .same_dst(same_dst)
  );

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic grp, legal;
    longint sz;
    e.w = w;
    grp = (w[29] == 1'b1) && (w[28] == 1'b0) && (w[27] == 1'b1) && w[22] &&
          (w[25:23] == 3'b001 || w[25:23] == 3'b010 || w[25:23] == 3'b011);
    sz = 0;
    if (w[26]) begin
      if (w[31:30] == 2'b00) sz = 4;
      else if (w[31:30] == 2'b01) sz = 8;
      else if (w[31:30] == 2'b10) sz = 16;
    end else begin
      if (w[31:30] == 2'b00) sz = 4;
      else if (w[31:30] == 2'b10) sz = 8;
    end
    legal = (sz != 0);
    e.ok  = grp && legal;
    e.bad = grp && !legal;
    e.vec = e.ok && w[26];
    e.nb  = e.ok ? 5'(sz) : 5'd0;
    e.md  = 2'b00;
    if (e.ok && w[25:23] == 3'b011) e.md = 2'b01;
    if (e.ok && w[25:23] == 3'b001) e.md = 2'b10;
    e.wbk = e.ok && (w[25:23] != 3'b010);
    e.pst = e.ok && (w[25:23] == 3'b001);
    e.off = e.ok ? OFF_W'(longint'($signed(w[21:15])) * sz) : '0;
    e.a   = w[4:0];
    e.b   = w[14:10];
    e.n   = w[9:5];
    e.sp  = e.ok && (w[9:5] == 5'd31);
    e.dup = e.ok && (w[4:0] == w[14:10]);
    return e;
  endfunction

  task automatic cmp(input string req, input string what, input longint act, input longint expv, input logic [31:0] w);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s insn=%08h actual=%0h expected=%0h", req, what, w, act, expv);
    end
  endtask

  task automatic drive(input logic [31:0] w);
    @(posedge clk);
    insn = w;
    q.push_back(model(w));
  endtask

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic v, input logic [2:0] f,
                                     input logic [6:0] imm, input logic [4:0] t2,
                                     input logic [4:0] n, input logic [4:0] t);
    return {sz, 3'b101, v, f, 1'b1, imm, t2, n, t};
  endfunction

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp("R1", "pair_ok", longint'(pair_ok), longint'(e.ok), e.w);
      cmp("R2", "bad_size", longint'(bad_size), longint'(e.bad), e.w);
      cmp("R3", "vec_rf", longint'(vec_rf), longint'(e.vec), e.w);
      cmp("R4", "elem_bytes", longint'(elem_bytes), longint'(e.nb), e.w);
      cmp("R5", "amode", longint'(amode), longint'(e.md), e.w);
      cmp("R5", "wb", longint'(wb), longint'(e.wbk), e.w);
      cmp("R5", "post", longint'(post), longint'(e.pst), e.w);
      cmp("R6", "byte_off", longint'(byte_off), longint'(e.off), e.w);
      cmp("R7", "rd_a", longint'(rd_a), longint'(e.a), e.w);
      cmp("R7", "rd_b", longint'(rd_b), longint'(e.b), e.w);
      cmp("R7", "rbase", longint'(rbase), longint'(e.n), e.w);
      cmp("R8", "base_sp", longint'(base_sp), longint'(e.sp), e.w);
      cmp("R9", "same_dst", longint'(same_dst), longint'(e.dup), e.w);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : driver
    logic [31:0] r;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(32'h0);                                   // reset-state word, R1
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 2; v++)
        for (int f = 0; f < 8; f++)
          drive(mk(2'(s), 1'(v), 3'(f), 7'h05, 5'd2, 5'd3, 5'd1)); // R1 R2 R4 R5
    for (int s = 0; s < 3; s++) begin               // R6 extremes
      drive(mk(2'(s), 1'b1, 3'b010, 7'h3F, 5'd4, 5'd6, 5'd7));
      drive(mk(2'(s), 1'b1, 3'b011, 7'h40, 5'd4, 5'd6, 5'd7));
      drive(mk(2'(s), 1'b1, 3'b001, 7'h7F, 5'd4, 5'd6, 5'd7));
      drive(mk(2'(s), 1'b0, 3'b010, 7'h40, 5'd4, 5'd6, 5'd7));
      drive(mk(2'(s), 1'b0, 3'b010, 7'h00, 5'd4, 5'd6, 5'd7));
    end
    drive(mk(2'b10, 1'b0, 3'b011, 7'h01, 5'd8, 5'd31, 5'd8)); // R8 R9 both
    drive(mk(2'b01, 1'b0, 3'b011, 7'h01, 5'd8, 5'd31, 5'd8)); // R8 R9 gated by illegal
    drive(mk(2'b11, 1'b1, 3'b010, 7'h01, 5'd9, 5'd31, 5'd9)); // R2
    drive(mk(2'b10, 1'b1, 3'b010, 7'h01, 5'd9, 5'd31, 5'd9) & ~32'h0040_0000); // store, R1
    drive(mk(2'b10, 1'b1, 3'b010, 7'h01, 5'd9, 5'd31, 5'd9) & ~32'h0800_0000); // R1
    drive(32'h2D40_0000);
    drive(32'hAD40_8420);
    drive(32'hA9C0_07E0);
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      if (i % 4 != 0) r[29:27] = 3'b101;
      if (i % 2 == 0) r[22] = 1'b1;
      drive(r);
    end
    @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin : finisher
    wait (drv_done);
    wait (q.size() == 0);
    @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule